// File: doc/BRIEF.md
# Byte-Split Program Counter

This block holds a 16-bit instruction address as two byte registers, a low half and a high half, for a datapath whose buses are one byte wide. A control unit writes either half from a shared byte bus, one half per load strobe, so a jump target arrives as two separate byte writes. A separate advance strobe steps the count by one. The low half has its own incrementer. The carry that incrementer produces is the only thing that makes the high half step.

The whole address is always visible on `pc_addr`, and there is no read strobe. The low byte also has its own port, so an arithmetic unit can add a relative branch displacement to it. A one-cycle registered flag reports each carry out of the low half. A sequencer can use it to see that a page boundary was crossed and that the high byte needs a correction.

All updates happen on the rising edge of `clk`. A synchronous, active-high `rst` clears both halves and the flag.

Top module: `split_pc_unit`

## Requirements
- R1: Two rising edges with `rst` high leave `pc_addr` at 0x0000 and `lo_carry_q` at 0. This holds whatever the other inputs do, and it also holds in the middle of a run.
- R2: When `load_lo` is high at an edge, the low half takes `data_in` on that edge.
- R3: When `load_hi` is high at an edge, the high half takes `data_in` on that edge. If `inc` is low, the low half keeps its value.
- R4: When `inc` is high, `load_lo` is low and the low half is not 0xFF, the low half goes up by one. The high half keeps its value unless `load_hi` is high.
- R5: When `inc` is high and the low half is 0xFF, the low half becomes 0x00 (unless `load_lo` is high) and the high half goes up by one (unless `load_hi` is high).
- R6: Advancing from 0xFFFF gives 0x0000.
- R7: When `load_lo` and `inc` are high in the same cycle, the low half takes `data_in`. The carry into the high half is still judged on the low half's value before the edge.
- R8: When `load_hi` and `inc` are high in the same cycle, the high half takes `data_in` and the low half still advances.
- R9: `lo_carry_q` is 1 in the cycle after an edge at which `inc` was high and the low half was 0xFF. In every other cycle after reset it is 0.
- R10: `pc_lo` always equals bits 7:0 of `pc_addr`. With no strobe high, an edge leaves `pc_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load_lo | input | 1 | Write `data_in` into the low half |
| load_hi | input | 1 | Write `data_in` into the high half |
| inc | input | 1 | Advance the count by one |
| data_in | input | 8 | Byte bus that feeds both halves |
| pc_addr | output | 16 | Full address, high half in bits 15:8 |
| pc_lo | output | 8 | Low half, for the branch adder |
| lo_carry_q | output | 1 | Registered carry out of the low half |

## Verification
The hardest cases to reach are the overlap cases. A load of one half and an advance happen in the same cycle, and the low half sits at 0xFF at that moment. Here the load priority and the carry that still passes to the other half interact. The stimulus reaches this state on purpose: it loads 0xFF into the low half, then raises `load_lo` together with `inc`. It repeats this with `load_hi` together with `inc`, and with both loads together with `inc`. A long stretch of random strobes follows, with the byte bus biased toward 0xFF, so that carries, wraps and overlaps keep recurring. The behavioural model is checked on every clock throughout.

// File: rtl/pc_split_pkg.sv
package pc_split_pkg;

    localparam int unsigned PC_HALF_W_DEF = 8;

    // What a half register does at the next edge
    typedef enum logic [1:0] {
        HALF_HOLD = 2'd0,
        HALF_BUMP = 2'd1,
        HALF_LOAD = 2'd2
    } half_op_e;

endpackage

// File: rtl/pc_half_incr.sv
module pc_half_incr #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] sum
);
    // Modulo-2^W step; the carry is produced by pc_carry_link
    assign sum = cur + W'(1);
endmodule

// File: rtl/pc_carry_link.sv
module pc_carry_link #(
    parameter int unsigned W = 8
) (
    input  logic         en_in,
    input  logic [W-1:0] cur,
    output logic         en_out
);
    // The next half steps only when this half rolls over
    assign en_out = en_in & (&cur);
endmodule

// File: rtl/pc_half_reg.sv
module pc_half_reg
    import pc_split_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  half_op_e     op,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] bump_val,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (op)
                HALF_LOAD: q <= load_val;
                HALF_BUMP: q <= bump_val;
                default:   q <= q;
            endcase
        end
    end
endmodule

// File: rtl/split_pc_unit.sv
module split_pc_unit
    import pc_split_pkg::*;
#(
    parameter int unsigned HALF_W = PC_HALF_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_lo,
    input  logic                load_hi,
    input  logic                inc,
    input  logic [HALF_W-1:0]   data_in,
    output logic [2*HALF_W-1:0] pc_addr,
    output logic [HALF_W-1:0]   pc_lo,
    output logic                lo_carry_q
);
    localparam int unsigned N_HALVES = 2;
    localparam int unsigned ADDR_W   = N_HALVES * HALF_W;

    logic [N_HALVES-1:0] ld_vec;
    logic [N_HALVES-1:0] en_h;
    logic [HALF_W-1:0]   q_h   [N_HALVES];
    logic [HALF_W-1:0]   sum_h [N_HALVES];
    half_op_e            op_h  [N_HALVES];
    logic [ADDR_W-1:0]   addr_w;

    assign ld_vec  = {load_hi, load_lo};
    assign en_h[0] = inc;

    for (genvar g = 0; g < N_HALVES; g++) begin : g_half
        pc_half_incr #(.W(HALF_W)) u_incr (
            .cur (q_h[g]),
            .sum (sum_h[g])
        );

        if (g < N_HALVES - 1) begin : g_link
            pc_carry_link #(.W(HALF_W)) u_link (
                .en_in  (en_h[g]),
                .cur    (q_h[g]),
                .en_out (en_h[g+1])
            );
        end

        // A load takes priority over a step for its own half
        always_comb begin
            if (ld_vec[g])     op_h[g] = HALF_LOAD;
            else if (en_h[g])  op_h[g] = HALF_BUMP;
            else               op_h[g] = HALF_HOLD;
        end

        pc_half_reg #(.W(HALF_W)) u_reg (
            .clk      (clk),
            .rst      (rst),
            .op       (op_h[g]),
            .load_val (data_in),
            .bump_val (sum_h[g]),
            .q        (q_h[g])
        );

        assign addr_w[g*HALF_W +: HALF_W] = q_h[g];
    end

    // Carry out of the low half, held for one cycle
    always_ff @(posedge clk) begin
        if (rst) lo_carry_q <= 1'b0;
        else     lo_carry_q <= en_h[1];
    end

    assign pc_addr = addr_w;
    assign pc_lo   = q_h[0];
endmodule

// File: rtl/split_pc_checker.sv
module split_pc_checker #(
    parameter int unsigned HALF_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                load_lo,
    input logic                load_hi,
    input logic                inc,
    input logic [HALF_W-1:0]   data_in,
    input logic [2*HALF_W-1:0] pc_addr,
    input logic [HALF_W-1:0]   pc_lo,
    input logic                lo_carry_q
);
    logic [HALF_W-1:0] hi_v;
    logic              lo_full;
    assign hi_v    = pc_addr[2*HALF_W-1:HALF_W];
    assign lo_full = &pc_lo;

    assert_load_lo_R2: assert property (@(posedge clk) disable iff (rst)
        load_lo |=> pc_lo == $past(data_in));

    assert_load_hi_R3: assert property (@(posedge clk) disable iff (rst)
        load_hi |=> hi_v == $past(data_in));

    assert_lo_step_R4: assert property (@(posedge clk) disable iff (rst)
        (inc && !load_lo) |=> pc_lo == HALF_W'($past(pc_lo) + 1'b1));

    assert_hi_keep_R4: assert property (@(posedge clk) disable iff (rst)
        (inc && !lo_full && !load_hi) |=> $stable(hi_v));

    assert_hi_step_R5: assert property (@(posedge clk) disable iff (rst)
        (inc && lo_full && !load_hi) |=> hi_v == HALF_W'($past(hi_v) + 1'b1));

    assert_carry_set_R9: assert property (@(posedge clk) disable iff (rst)
        (inc && lo_full) |=> lo_carry_q);

    assert_carry_clr_R9: assert property (@(posedge clk) disable iff (rst)
        !(inc && lo_full) |=> !lo_carry_q);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!load_lo && !load_hi && !inc) |=> $stable(pc_addr));

    assert_lo_alias_R10: assert property (@(posedge clk) disable iff (rst)
        pc_lo == pc_addr[HALF_W-1:0]);
endmodule

bind split_pc_unit split_pc_checker #(.HALF_W(HALF_W)) u_split_pc_checker (
    .clk        (clk),
    .rst        (rst),
    .load_lo    (load_lo),
    .load_hi    (load_hi),
    .inc        (inc),
    .data_in    (data_in),
    .pc_addr    (pc_addr),
    .pc_lo      (pc_lo),
    .lo_carry_q (lo_carry_q)
);

// File: tb/test_split_pc_unit.sv
module test_split_pc_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_lo = 1'b0;
    logic        load_hi = 1'b0;
    logic        inc = 1'b0;
    logic [7:0]  data_in = 8'h00;
    logic [15:0] pc_addr;
    logic [7:0]  pc_lo;
    logic        lo_carry_q;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    // Reference model state
    int m_lo = 0;
    int m_hi = 0;
    int m_cf = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    split_pc_unit i_split_pc_unit (
        .clk        (clk),
        .rst        (rst),
        .load_lo    (load_lo),
        .load_hi    (load_hi),
        .inc        (inc),
        .data_in    (data_in),
        .pc_addr    (pc_addr),
        .pc_lo      (pc_lo),
        .lo_carry_q (lo_carry_q)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        check({tag, " pc_addr"}, int'(pc_addr), m_hi * 256 + m_lo);
        check({tag, " lo_carry_q"}, int'(lo_carry_q), m_cf);
        check({tag, " pc_lo R10"}, int'(pc_lo), m_lo);
    endtask

    // One clock: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input bit r, input bit ll, input bit lh, input bit in,
                        input logic [7:0] d, input string tag);
        int carry;
        rst = r; load_lo = ll; load_hi = lh; inc = in; data_in = d;
        @(posedge clk);
        if (r) begin
            m_lo = 0; m_hi = 0; m_cf = 0;
        end else begin
            carry = (in && m_lo == 255) ? 1 : 0;
            m_lo = ll ? int'(d) : (in ? (m_lo + 1) % 256 : m_lo);
            m_hi = lh ? int'(d) : (carry == 1 ? (m_hi + 1) % 256 : m_hi);
            m_cf = carry;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(1, 1, 1, 1, 8'hAA, "R1 reset");
        step(1, 0, 0, 0, 8'h00, "R1 reset");
        step(0, 1, 0, 0, 8'h34, "R2 load low");
        step(0, 0, 1, 0, 8'h12, "R3 load high");
        step(0, 0, 0, 0, 8'h77, "R10 idle");
        for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 8'h00, "R4 advance");
        step(0, 1, 0, 0, 8'hFE, "R2 load low");
        step(0, 0, 0, 1, 8'h00, "R4 advance to FF");
        step(0, 0, 0, 1, 8'h00, "R5 carry into high");
        step(0, 0, 0, 0, 8'h00, "R9 flag clears");
        step(0, 1, 0, 0, 8'hFF, "R2 load low");
        step(0, 0, 1, 0, 8'hFF, "R3 load high");
        step(0, 0, 0, 1, 8'h00, "R6 wrap to zero");
        step(0, 1, 0, 0, 8'hFF, "R2 load low");
        step(0, 1, 0, 1, 8'h40, "R7 load low with advance");
        step(0, 1, 0, 0, 8'hFF, "R2 load low");
        step(0, 0, 1, 1, 8'h90, "R8 load high with advance");
        step(0, 1, 0, 0, 8'hFF, "R2 load low");
        step(0, 1, 1, 1, 8'h05, "R7 both loads with advance");
        step(0, 0, 0, 0, 8'h00, "R10 idle");
        step(1, 0, 0, 1, 8'h00, "R1 reset mid run");
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] d;
            d = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom);
            step(0, ($urandom % 5) == 0, ($urandom % 7) == 0,
                 ($urandom % 3) != 0, d, "R10 random");
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end
endmodule